// File: doc/BRIEF.md
# PHY Test-Port Configuration Sequencer

This block drives the narrow byte-wide test and configuration port of a display PHY. Every register write on that port is a three-phase exchange. The falling edge of the port clock latches an 8-bit register code. The next rising edge, with the enable low, commits an 8-bit data byte. Each phase is held for a programmable number of system clocks.

Software or a neighbouring controller can issue single code/data writes through a valid/ready handshake. A built-in init program can also be started. It takes the lane rate and the PLL input and feedback divider values, and issues a fixed series of twenty writes. These cover the PLL range, the dividers, bias, termination and the clock-lane and data-lane timing registers.

The timing values are derived on the fly from the lane rate. One shared converter turns nanoseconds into byte-clock counts or unit-interval counts.

Top module: `phy_test_cfg`

## Requirements
- R1: While reset is asserted, test_clk_o is high, test_en_o is low, test_din_o is 0, test_clr_o is high and busy_o is low. test_clr_o goes low at the first clock edge after reset and stays low.
- R2: A write holds three phases of PHASE_CYC clocks each. In setup, clock is high, enable is low and din is 0. In code, clock is low, enable is high and din is the code. In data, clock is high, enable is low and din is the data. So each low period of test_clk_o lasts exactly PHASE_CYC clocks, the code is latched on the falling edge and the data is committed on the rising edge.
- R3: A host write is accepted at the clock edge where req_valid_i and req_ready_o are both high. After that edge, busy_o is high and req_ready_o is low for exactly 3*PHASE_CYC clocks. A req_valid_i pulse while req_ready_o is low produces no write.
- R4: A high init_start_i is taken only while the block is idle, and it wins over a host request in the same cycle. lane_mbps_i, in_div_i and fb_div_i are sampled at that edge, and later changes have no effect on the run. req_ready_o stays low until the run ends. The run issues 20 writes in a fixed order.
- R5: Write 1 goes to code 0x10 with data 0x83 | (V<<3). V is 0 if the rate is below 200, otherwise ((rate+100)/200) mod 8.
- R6: Write 2 goes to code 0x17 with data (N-1) mod 128.
- R7: Writes 3 to 6 form the split loop-divider sequence, in this order:
  - code 0x18 with (M-1) mod 32 and bit 7 clear;
  - code 0x19 with 0x30;
  - code 0x18 with 0x80 | (((M-1)>>5) mod 16);
  - code 0x19 with 0x30 again.
- R8: Writes 7 to 9 are fixed, in this order: code 0x20 with 0x4D, code 0x21 with 0x3D, and code 0x21 with 0xDF.
- R9: With rate r in Mbps and a time t in ns, the byte-clock count is ceil(floor(t*r/8)/1000) and the unit-interval count is ceil(t*r/1000). Written timing data is the enable bits OR the count plus its offset, truncated to 8 bits.
- R10: Writes 10 to 15 go to codes 0x60 to 0x65 with these values:
  - 0x60: 0x80|bc(500)
  - 0x61: 0x80|ui(40)
  - 0x62: 0x40|bc(300)
  - 0x63: 0x80|ui(100)
  - 0x64: 0x20|bc(100)
  - 0x65: 0x20|(bc(60)+7)
- R11: Writes 16 to 20 go to codes 0x70 to 0x74 with these values:
  - 0x70: 0x80|bc(500)
  - 0x71: 0x80|(ui(50)+20)
  - 0x72: 0x40|(bc(140)+2)
  - 0x73: 0x80|(ui(60)+8)
  - 0x74: 0x20|bc(100)
- R12: init_done_o is high for exactly one clock, in the cycle in which busy_o falls after the last write of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host write request valid |
| req_ready_o | output | 1 | Host write request can be taken |
| req_code_i | input | 8 | Host register code |
| req_data_i | input | 8 | Host data byte |
| init_start_i | input | 1 | Start the built-in init program |
| lane_mbps_i | input | RATE_W | Lane rate in Mbps |
| in_div_i | input | NDIV_W | PLL input divider N |
| fb_div_i | input | MDIV_W | PLL feedback divider M |
| test_clk_o | output | 1 | Port clock to the PHY |
| test_clr_o | output | 1 | Port clear to the PHY |
| test_en_o | output | 1 | Port enable, high while a code is presented |
| test_din_o | output | 8 | Port code/data byte |
| busy_o | output | 1 | A write or an init run is in progress |
| init_done_o | output | 1 | One-cycle pulse at the end of an init run |

## Verification
The assertions assume two things about the environment: the write engine is only started while idle, and the divider inputs are at least 1, so N-1 and M-1 do not wrap. The stimulus meets both. It drives each request only after seeing req_ready_o high, and it picks N and M from their legal ranges. To exercise the sampling at start, it moves the rate and divider inputs in the middle of a run. It also pulses valid during busy periods to confirm that no extra write is produced.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PROG_LEN = 20;
  localparam int unsigned IDX_W    = $clog2(PROG_LEN);
  localparam int unsigned NS_W     = 10;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_CODE, PH_DATA} port_ph_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DRAIN} seq_st_e;
  typedef enum logic [1:0] {VAL_FIX, VAL_BC, VAL_UI} val_kind_e;

  typedef struct packed {
    logic [BYTE_W-1:0] code;
    logic [BYTE_W-1:0] data;
  } port_wr_t;
endpackage

// File: rtl/phy_test_cfg_tconv.sv
module phy_test_cfg_tconv #(
  parameter int unsigned RATE_W = 11,
  parameter int unsigned NS_W   = 10,
  parameter int unsigned CNT_W  = 11
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic              ui_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned PROD_W = RATE_W + NS_W + 1;

  logic [PROD_W-1:0] prod, scaled, quo;

  always_comb begin
    prod   = PROD_W'(rate_i) * PROD_W'(ns_i);
    // byte clock: truncate the /8 first, round up the /1000
    scaled = ui_i ? prod : (prod >> 3);
    quo    = (scaled + PROD_W'(999)) / PROD_W'(1000);
    cnt_o  = CNT_W'(quo);
  end
endmodule

// File: rtl/phy_test_cfg_prog.sv
module phy_test_cfg_prog
  import phy_cfg_pkg::*;
#(
  parameter int unsigned RATE_W = 11,
  parameter int unsigned NDIV_W = 8,
  parameter int unsigned MDIV_W = 10
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [NDIV_W-1:0] ndiv_i,
  input  logic [MDIV_W-1:0] mdiv_i,
  output port_wr_t          wr_o
);
  localparam int unsigned CNT_W = RATE_W;

  logic [MDIV_W-1:0] m_m1;
  logic [NDIV_W-1:0] n_m1;
  logic [RATE_W:0]   rate_p;
  logic [2:0]        vco;
  val_kind_e         kind;
  logic [NS_W-1:0]   ns;
  logic [7:0]        base, add, fix, code;
  logic [CNT_W-1:0]  cnt;

  phy_test_cfg_tconv #(.RATE_W(RATE_W), .NS_W(NS_W), .CNT_W(CNT_W)) u_tconv (
    .rate_i (rate_i),
    .ns_i   (ns),
    .ui_i   (kind == VAL_UI),
    .cnt_o  (cnt)
  );

  always_comb begin
    m_m1   = mdiv_i - MDIV_W'(1);
    n_m1   = ndiv_i - NDIV_W'(1);
    rate_p = {1'b0, rate_i} + (RATE_W+1)'(100);
    vco    = (rate_i < RATE_W'(200)) ? 3'd0 : 3'(rate_p / (RATE_W+1)'(200));
    code = 8'h00; base = 8'h00; add = 8'h00; fix = 8'h00;
    kind = VAL_FIX; ns = '0;
    case (int'(idx_i))
      0:  begin code = 8'h10; fix = 8'h83 | {2'b00, vco, 3'b000}; end
      1:  begin code = 8'h17; fix = 8'(n_m1) & 8'h7f; end
      2:  begin code = 8'h18; fix = 8'(m_m1) & 8'h1f; end
      3:  begin code = 8'h19; fix = 8'h30; end
      4:  begin code = 8'h18; fix = 8'h80 | (8'(m_m1 >> 5) & 8'h0f); end
      5:  begin code = 8'h19; fix = 8'h30; end
      6:  begin code = 8'h20; fix = 8'h4d; end
      7:  begin code = 8'h21; fix = 8'h3d; end
      8:  begin code = 8'h21; fix = 8'hdf; end
      9:  begin code = 8'h60; base = 8'h80; kind = VAL_BC; ns = NS_W'(500); end
      10: begin code = 8'h61; base = 8'h80; kind = VAL_UI; ns = NS_W'(40); end
      11: begin code = 8'h62; base = 8'h40; kind = VAL_BC; ns = NS_W'(300); end
      12: begin code = 8'h63; base = 8'h80; kind = VAL_UI; ns = NS_W'(100); end
      13: begin code = 8'h64; base = 8'h20; kind = VAL_BC; ns = NS_W'(100); end
      14: begin code = 8'h65; base = 8'h20; kind = VAL_BC; ns = NS_W'(60); add = 8'd7; end
      15: begin code = 8'h70; base = 8'h80; kind = VAL_BC; ns = NS_W'(500); end
      16: begin code = 8'h71; base = 8'h80; kind = VAL_UI; ns = NS_W'(50); add = 8'd20; end
      17: begin code = 8'h72; base = 8'h40; kind = VAL_BC; ns = NS_W'(140); add = 8'd2; end
      18: begin code = 8'h73; base = 8'h80; kind = VAL_UI; ns = NS_W'(60); add = 8'd8; end
      19: begin code = 8'h74; base = 8'h20; kind = VAL_BC; ns = NS_W'(100); end
      default: ;
    endcase
    wr_o.code = code;
    wr_o.data = (kind == VAL_FIX) ? fix : (base | 8'(cnt + CNT_W'(add)));
  end
endmodule

// File: rtl/phy_test_cfg_port.sv
module phy_test_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int unsigned PHASE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  port_wr_t          wr_i,
  output logic              busy_o,
  output logic              tclk_o,
  output logic              tclr_o,
  output logic              ten_o,
  output logic [BYTE_W-1:0] tdin_o
);
  localparam int unsigned PH    = (PHASE_CYC < 2) ? 2 : PHASE_CYC;
  localparam int unsigned CNT_W = $clog2(PH);

  port_ph_e          ph_q;
  logic [CNT_W-1:0]  cnt_q;
  port_wr_t          wr_q;
  logic              tclk_q, tclr_q, ten_q;
  logic [BYTE_W-1:0] tdin_q;
  logic              last;

  assign last = (cnt_q == CNT_W'(PH-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= '0;
      tclk_q <= 1'b1;
      tclr_q <= 1'b1;
      ten_q  <= 1'b0;
      tdin_q <= '0;
    end else begin
      tclr_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          wr_q   <= wr_i;
          ph_q   <= PH_SETUP;
          cnt_q  <= '0;
          tclk_q <= 1'b1;
          ten_q  <= 1'b0;
          tdin_q <= '0;
        end
        PH_SETUP: if (last) begin
          ph_q   <= PH_CODE;
          cnt_q  <= '0;
          tclk_q <= 1'b0;
          ten_q  <= 1'b1;
          tdin_q <= wr_q.code;
        end else cnt_q <= cnt_q + CNT_W'(1);
        PH_CODE: if (last) begin
          ph_q   <= PH_DATA;
          cnt_q  <= '0;
          tclk_q <= 1'b1;
          ten_q  <= 1'b0;
          tdin_q <= wr_q.data;
        end else cnt_q <= cnt_q + CNT_W'(1);
        PH_DATA: if (last) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign tclk_o = tclk_q;
  assign tclr_o = tclr_q;
  assign ten_o  = ten_q;
  assign tdin_o = tdin_q;

  p_clr_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> !tclr_o);
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |-> !busy_o);
  p_fall_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(tclk_o) |-> ten_o);
  p_rise_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(tclk_o) |-> !ten_o);
  p_din_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclk_o && !$fell(tclk_o)) |-> $stable(tdin_o));
endmodule

// File: rtl/phy_test_cfg_ctrl.sv
module phy_test_cfg_ctrl
  import phy_cfg_pkg::*;
#(
  parameter int unsigned RATE_W = 11,
  parameter int unsigned NDIV_W = 8,
  parameter int unsigned MDIV_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_start_i,
  input  logic              eng_busy_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [NDIV_W-1:0] ndiv_i,
  input  logic [MDIV_W-1:0] mdiv_i,
  output logic              active_o,
  output logic              issue_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic [MDIV_W-1:0] mdiv_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PROG_LEN-1);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RATE_W-1:0] rate_q;
  logic [NDIV_W-1:0] ndiv_q;
  logic [MDIV_W-1:0] mdiv_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      rate_q <= '0;
      ndiv_q <= '0;
      mdiv_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (init_start_i && !eng_busy_i) begin
          st_q   <= SQ_RUN;
          idx_q  <= '0;
          rate_q <= rate_i;
          ndiv_q <= ndiv_i;
          mdiv_q <= mdiv_i;
        end
        SQ_RUN: if (!eng_busy_i) begin
          if (idx_q == LAST) st_q <= SQ_DRAIN;
          else idx_q <= idx_q + IDX_W'(1);
        end
        SQ_DRAIN: if (!eng_busy_i) begin
          st_q   <= SQ_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign active_o = (st_q != SQ_IDLE);
  assign issue_o  = (st_q == SQ_RUN) && !eng_busy_i;
  assign idx_o    = idx_q;
  assign rate_o   = rate_q;
  assign ndiv_o   = ndiv_q;
  assign mdiv_o   = mdiv_q;
  assign done_o   = done_q;

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) active_o |-> idx_o <= LAST);
endmodule

// File: rtl/phy_test_cfg.sv
module phy_test_cfg
  import phy_cfg_pkg::*;
#(
  parameter int unsigned PHASE_CYC = 4,
  parameter int unsigned RATE_W    = 11,
  parameter int unsigned NDIV_W    = 8,
  parameter int unsigned MDIV_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_code_i,
  input  logic [7:0]        req_data_i,
  input  logic              init_start_i,
  input  logic [RATE_W-1:0] lane_mbps_i,
  input  logic [NDIV_W-1:0] in_div_i,
  input  logic [MDIV_W-1:0] fb_div_i,
  output logic              test_clk_o,
  output logic              test_clr_o,
  output logic              test_en_o,
  output logic [7:0]        test_din_o,
  output logic              busy_o,
  output logic              init_done_o
);
  logic              eng_busy, eng_start;
  logic              seq_active, seq_issue, host_fire;
  logic [IDX_W-1:0]  seq_idx;
  logic [RATE_W-1:0] seq_rate;
  logic [NDIV_W-1:0] seq_ndiv;
  logic [MDIV_W-1:0] seq_mdiv;
  port_wr_t          prog_wr, eng_wr;

  phy_test_cfg_ctrl #(.RATE_W(RATE_W), .NDIV_W(NDIV_W), .MDIV_W(MDIV_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_start_i (init_start_i),
    .eng_busy_i   (eng_busy),
    .rate_i       (lane_mbps_i),
    .ndiv_i       (in_div_i),
    .mdiv_i       (fb_div_i),
    .active_o     (seq_active),
    .issue_o      (seq_issue),
    .idx_o        (seq_idx),
    .rate_o       (seq_rate),
    .ndiv_o       (seq_ndiv),
    .mdiv_o       (seq_mdiv),
    .done_o       (init_done_o)
  );

  phy_test_cfg_prog #(.RATE_W(RATE_W), .NDIV_W(NDIV_W), .MDIV_W(MDIV_W)) u_prog (
    .idx_i  (seq_idx),
    .rate_i (seq_rate),
    .ndiv_i (seq_ndiv),
    .mdiv_i (seq_mdiv),
    .wr_o   (prog_wr)
  );

  // init program owns the port; a same-cycle start blocks the host
  assign req_ready_o = !eng_busy && !seq_active && !init_start_i;
  assign host_fire   = req_valid_i && req_ready_o;
  assign eng_start   = seq_issue || host_fire;
  assign eng_wr      = seq_issue ? prog_wr : port_wr_t'{code: req_code_i, data: req_data_i};
  assign busy_o      = eng_busy || seq_active;

  phy_test_cfg_port #(.PHASE_CYC(PHASE_CYC)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .wr_i    (eng_wr),
    .busy_o  (eng_busy),
    .tclk_o  (test_clk_o),
    .tclr_o  (test_clr_o),
    .ten_o   (test_en_o),
    .tdin_o  (test_din_o)
  );

  p_init_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_active) |-> $past(init_start_i));
  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/phy_test_cfg_tb.sv
module phy_test_cfg_tb;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_code = '0, req_data = '0;
  logic        init_start = 1'b0;
  logic [10:0] lane_mbps = 11'd1000;
  logic [7:0]  in_div = 8'd1;
  logic [9:0]  fb_div = 10'd100;
  logic        tclk, tclr, ten, busy, done;
  logic [7:0]  tdin;

  phy_test_cfg #(.PHASE_CYC(PH)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_code_i (req_code), .req_data_i (req_data),
    .init_start_i (init_start), .lane_mbps_i (lane_mbps),
    .in_div_i (in_div), .fb_div_i (fb_div),
    .test_clk_o (tclk), .test_clr_o (tclr), .test_en_o (ten),
    .test_din_o (tdin), .busy_o (busy), .init_done_o (done)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // port-level PHY model: latch code on fall, commit data on rise
  logic [7:0] log_code [256];
  logic [7:0] log_data [256];
  int   n_wr = 0;
  logic prev_clk = 1'b1;
  logic [7:0] lat_code = '0;
  bit   have_code = 0;
  int   low_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_clk && !tclk) begin
        low_len = 0;
        if (ten) begin lat_code = tdin; have_code = 1; end
      end
      if (!tclk) low_len++;
      if (!prev_clk && tclk) begin
        chk("R2", "low phase length", low_len, PH);
        if (!ten && have_code) begin
          log_code[n_wr & 255] = lat_code;
          log_data[n_wr & 255] = tdin;
          n_wr++;
          have_code = 0;
        end
      end
    end
    prev_clk = tclk;
  end

  function automatic int bc(int ns, int r); return ((ns * r / 8) + 999) / 1000; endfunction
  function automatic int ui(int ns, int r); return (ns * r + 999) / 1000; endfunction

  function automatic logic [15:0] exp_step(int i, int r, int n, int m);
    logic [7:0] c, d;
    int v;
    c = 8'h00; d = 8'h00;
    case (i)
      0:  begin c = 8'h10; v = (r < 200) ? 0 : ((r + 100) / 200) % 8; d = 8'h83 | 8'(v << 3); end
      1:  begin c = 8'h17; d = 8'((n - 1) % 128); end
      2:  begin c = 8'h18; d = 8'((m - 1) % 32); end
      3:  begin c = 8'h19; d = 8'h30; end
      4:  begin c = 8'h18; d = 8'h80 | 8'(((m - 1) >> 5) % 16); end
      5:  begin c = 8'h19; d = 8'h30; end
      6:  begin c = 8'h20; d = 8'h4d; end
      7:  begin c = 8'h21; d = 8'h3d; end
      8:  begin c = 8'h21; d = 8'hdf; end
      9:  begin c = 8'h60; d = 8'h80 | 8'(bc(500, r)); end
      10: begin c = 8'h61; d = 8'h80 | 8'(ui(40, r)); end
      11: begin c = 8'h62; d = 8'h40 | 8'(bc(300, r)); end
      12: begin c = 8'h63; d = 8'h80 | 8'(ui(100, r)); end
      13: begin c = 8'h64; d = 8'h20 | 8'(bc(100, r)); end
      14: begin c = 8'h65; d = 8'h20 | 8'(bc(60, r) + 7); end
      15: begin c = 8'h70; d = 8'h80 | 8'(bc(500, r)); end
      16: begin c = 8'h71; d = 8'h80 | 8'(ui(50, r) + 20); end
      17: begin c = 8'h72; d = 8'h40 | 8'(bc(140, r) + 2); end
      18: begin c = 8'h73; d = 8'h80 | 8'(ui(60, r) + 8); end
      19: begin c = 8'h74; d = 8'h20 | 8'(bc(100, r)); end
      default: ;
    endcase
    return {c, d};
  endfunction

  function automatic string req_of(int i);
    if (i == 0) return "R5";
    if (i == 1) return "R6";
    if (i <= 5) return "R7";
    if (i <= 8) return "R8";
    if (i <= 14) return "R10 R9";
    return "R11 R9";
  endfunction

  task automatic host_write(logic [7:0] c, logic [7:0] d);
    int base, blen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base = n_wr;
    req_valid = 1'b1; req_code = c; req_data = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    blen = 0;
    @(negedge clk);
    while (busy && blen < 1000) begin
      if (req_ready) chk("R3", "ready during busy", 1, 0);
      blen++;
      @(negedge clk);
    end
    chk("R3", "busy length", blen, 3 * PH);
    chk("R2", "write count", n_wr - base, 1);
    chk("R2", "code", log_code[base & 255], c);
    chk("R2", "data", log_data[base & 255], d);
  endtask

  task automatic run_init(int r, int n, int m, bit with_host);
    int base, g, bad_ready;
    @(negedge clk);
    while (busy) @(negedge clk);
    lane_mbps = 11'(r); in_div = 8'(n); fb_div = 10'(m);
    init_start = 1'b1;
    if (with_host) begin req_valid = 1'b1; req_code = 8'hee; req_data = 8'h55; end
    base = n_wr;
    @(posedge clk); #1;
    init_start = 1'b0; req_valid = 1'b0;
    // later input changes must not affect the run (R4)
    lane_mbps = 11'd777; in_div = 8'd9; fb_div = 10'd333;
    g = 0; bad_ready = 0;
    @(negedge clk);
    while (!done && g < 2000) begin
      if (req_ready) bad_ready++;
      g++;
      @(negedge clk);
    end
    chk("R4", "ready low during run", bad_ready, 0);
    chk("R12", "done seen", int'(done), 1);
    chk("R12", "busy low with done", int'(busy), 0);
    chk("R4", "write count", n_wr - base, 20);
    for (int i = 0; i < 20; i++) begin
      logic [15:0] e;
      e = exp_step(i, r, n, m);
      chk(req_of(i), $sformatf("step %0d code", i), log_code[(base + i) & 255], e[15:8]);
      chk(req_of(i), $sformatf("step %0d data", i), log_data[(base + i) & 255], e[7:0]);
    end
    @(negedge clk);
    chk("R12", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "clk in reset", int'(tclk), 1);
    chk("R1", "en in reset", int'(ten), 0);
    chk("R1", "din in reset", int'(tdin), 0);
    chk("R1", "clr in reset", int'(tclr), 1);
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "clr after reset", int'(tclr), 0);
    chk("R1", "ready after reset", int'(req_ready), 1);

    host_write(8'h44, 8'h5a);
    host_write(8'h00, 8'hff);
    for (int k = 0; k < 12; k++) host_write(8'($urandom), 8'($urandom));

    // valid pulse while busy must not create a write (R3)
    base = n_wr;
    @(negedge clk);
    req_valid = 1'b1; req_code = 8'h12; req_data = 8'h34;
    @(posedge clk); #1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_code = 8'hee; req_data = 8'hee;
    @(negedge clk); req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3 * PH) @(negedge clk);
    chk("R3", "pulse during busy ignored", n_wr - base, 1);
    chk("R3", "last code kept", log_code[(n_wr - 1) & 255], 8'h12);

    run_init(150, 3, 100, 0);
    run_init(199, 1, 6, 0);
    run_init(200, 2, 512, 0);
    run_init(1000, 128, 250, 0);
    run_init(1500, 5, 37, 0);
    run_init(2047, 7, 480, 0);
    for (int k = 0; k < 3; k++)
      run_init(80 + int'($urandom % 1968), 1 + int'($urandom % 128), 6 + int'($urandom % 507), 0);
    // same-cycle init start and host request: init wins (R4)
    run_init(480, 4, 160, 1);
    host_write(8'h7e, 8'h81);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule